// File: doc/BRIEF.md
# Radix-4 Sign-Magnitude Sequential Multiplier

This block multiplies two sign-magnitude operands that have 35-bit magnitudes. It holds the multiplicand in one register, the multiplier in a second register that also collects the low half of the product, and the high half of the product in an accumulator. Each working cycle retires two multiplier bits as one base-4 digit. A digit of three is done by subtracting the multiplicand and setting a string flag. That flag adds one to the next digit, so the partial product may pass through two's-complement form. It returns to true form at the next true add. If the flag is still set once all digits are used, one closing add of the multiplicand restores the true product.

A caller loads both operands with a one-cycle `start` pulse while the block is idle. The caller then waits for the one-cycle `done` pulse. Three variants are chosen by `mode`. The fixed-length variant multiplies all 35 magnitude bits. The variable-length variant uses only the low `count_in` multiplier bits: the product then fills the accumulator and the top of the multiplier register, and the untouched high multiplier bits stay below it. The round variant adds one to the accumulator when the top bit of the low half is set.

Top module: `radix4_mult`

## Requirements
- R1: After reset, `busy`, `done`, `acc_qp`, `acc_mag`, `mq_mag`, `acc_sign` and `mq_sign` are all zero.
- R2: With `mode[1]`=0, the 70-bit product of the two magnitudes is returned with bits 69..35 on `acc_mag` and bits 34..0 on `mq_mag`.
- R3: At completion, `acc_sign` and `mq_sign` both equal the XOR of the two operand signs, in every mode and also for a zero product.
- R4: The result is exact for every multiplier bit pattern, including runs of ones that are handled through the string flag and the closing add. The partial product is negative only while the string flag is set, and the flag is clear after the closing step.
- R5: With `mode[1]`=1, let n be `count_in`, with values above 35 taken as 35. Then {`acc_mag`,`mq_mag`} equals (mcand × (mplier mod 2^n)) shifted left by 35−n, OR'd with (mplier >> n). For n=0 this gives `acc_mag`=0 and `mq_mag`=mplier.
- R6: With `mode[0]`=1, one is added to `acc_mag` after the multiply when bit 34 of `mq_mag` is 1. Otherwise `acc_mag` is left unchanged.
- R7: At completion, the two overflow bits `acc_qp` are zero.
- R8: `done` is a one-cycle pulse. `busy` is high from the accepting edge through the `done` cycle and low afterwards. Results hold until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored, and the running operation completes with its original operands.
- R10: The digit counter drops by two per iteration, or by one when it stands at 1. `done` is first seen ceil(n/2)+2 rising edges after the accepting edge, plus one more edge when rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load operands and begin; sampled only when idle |
| mode | input | 2 | bit1: variable length, bit0: round |
| count_in | input | 6 | Digit count for variable length |
| md_sign | input | 1 | Multiplicand sign (1 = negative) |
| md_mag | input | 35 | Multiplicand magnitude |
| mr_sign | input | 1 | Multiplier sign |
| mr_mag | input | 35 | Multiplier magnitude |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_sign | output | 1 | Accumulator sign |
| acc_qp | output | 2 | Accumulator overflow bits |
| acc_mag | output | 35 | High product half |
| mq_sign | output | 1 | Multiplier-register sign |
| mq_mag | output | 35 | Low product half / remaining multiplier bits |

## Verification
The assertions check on every cycle that `done` lasts one cycle, and that `busy` covers it. They also check that the counter only moves downward and that the partial product is never negative without a pending string flag. At each completion they check that the flag has been cleared, that the overflow bits are zero and that the two signs agree. Only the bench scenarios show that the numeric results are correct. This covers runs of ones, all-ones operands, rounding on both sides of the threshold, variable counts of zero, odd values and values above 35, the exact latency, and that a start during a running operation is ignored.

// File: rtl/radix4_mult.sv
module radix4_mult #(
  parameter int N  = 35,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] count_in,
  input  logic          md_sign,
  input  logic [N-1:0]  md_mag,
  input  logic          mr_sign,
  input  logic [N-1:0]  mr_mag,
  output logic          busy,
  output logic          done,
  output logic          acc_sign,
  output logic [1:0]    acc_qp,
  output logic [N-1:0]  acc_mag,
  output logic          mq_sign,
  output logic [N-1:0]  mq_mag
);
  localparam int AW = N + 3;
  localparam logic [CW-1:0] FULL = CW'(N);
  localparam logic signed [AW-1:0] ONE = AW'(1);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FIX, S_RND, S_DONE} st_t;

  st_t                   st;
  logic [N-1:0]          sr, mq;
  logic signed [AW-1:0]  ac;
  logic [CW-1:0]         cnt;
  logic                  strb, rnd, psign;

  logic                  last1;
  logic [2:0]            dig;
  logic signed [AW-1:0]  mx, addend, sum;
  logic                  nstr;
  logic                  in_run, in_fix, ac_neg;

  assign last1 = (cnt == CW'(1));
  assign dig   = last1 ? ({2'b0, mq[0]} + {2'b0, strb})
                       : ({1'b0, mq[1:0]} + {2'b0, strb});
  assign mx    = {3'b000, sr};

  always_comb begin
    addend = '0;
    nstr   = 1'b0;
    case (dig)
      3'd1: addend = mx;
      3'd2: if (last1) nstr = 1'b1;
            else       addend = mx <<< 1;
      3'd3: begin addend = -mx; nstr = 1'b1; end
      3'd4: nstr = 1'b1;
      default: ;
    endcase
  end

  assign sum = ac + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sr    <= '0;
      mq    <= '0;
      ac    <= '0;
      cnt   <= '0;
      strb  <= 1'b0;
      rnd   <= 1'b0;
      psign <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sr    <= md_mag;
          mq    <= mr_mag;
          ac    <= '0;
          strb  <= 1'b0;
          rnd   <= mode[0];
          psign <= md_sign ^ mr_sign;
          cnt   <= (mode[1] && count_in <= FULL) ? count_in : FULL;
          st    <= S_RUN;
        end
        S_RUN: begin
          if (cnt == '0) begin
            st <= S_FIX;
          end else if (last1) begin
            ac   <= sum >>> 1;
            mq   <= {sum[0], mq[N-1:1]};
            strb <= nstr;
            cnt  <= '0;
          end else begin
            ac   <= sum >>> 2;
            mq   <= {sum[1:0], mq[N-1:2]};
            strb <= nstr;
            cnt  <= cnt - CW'(2);
          end
        end
        S_FIX: begin
          if (strb) ac <= ac + mx;
          strb <= 1'b0;
          st   <= rnd ? S_RND : S_DONE;
        end
        S_RND: begin
          if (mq[N-1]) ac <= ac + ONE;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign acc_sign = psign;
  assign mq_sign  = psign;
  assign acc_qp   = ac[N+1:N];
  assign acc_mag  = ac[N-1:0];
  assign mq_mag   = mq;
  assign in_run   = (st == S_RUN);
  assign in_fix   = (st == S_FIX);
  assign ac_neg   = ac[AW-1];
endmodule

// File: rtl/radix4_mult_chk.sv
module radix4_mult_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy,
  input logic          in_run,
  input logic          in_fix,
  input logic          strb,
  input logic          ac_neg,
  input logic          acc_sign,
  input logic          mq_sign,
  input logic [1:0]    acc_qp,
  input logic [CW-1:0] cnt
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_qp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> acc_qp == 2'b00);
  assert_sign_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> acc_sign == mq_sign);
  assert_cnt_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && cnt != '0) |=> cnt < $past(cnt));
  assert_string_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fix |=> !strb);
  assert_cmpl_only_string_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !strb) |-> !ac_neg);
endmodule

bind radix4_mult radix4_mult_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy),
  .in_run(in_run), .in_fix(in_fix), .strb(strb), .ac_neg(ac_neg),
  .acc_sign(acc_sign), .mq_sign(mq_sign), .acc_qp(acc_qp), .cnt(cnt)
);

// File: tb/radix4_mult_tb.sv
module radix4_mult_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [5:0] count_in = '0;
  logic md_sign = 1'b0, mr_sign = 1'b0;
  logic [34:0] md_mag = '0, mr_mag = '0;
  logic busy, done, acc_sign, mq_sign;
  logic [1:0] acc_qp;
  logic [34:0] acc_mag, mq_mag;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  radix4_mult dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count_in(count_in),
    .md_sign(md_sign), .md_mag(md_mag), .mr_sign(mr_sign), .mr_mag(mr_mag),
    .busy(busy), .done(done), .acc_sign(acc_sign), .acc_qp(acc_qp),
    .acc_mag(acc_mag), .mq_sign(mq_sign), .mq_mag(mq_mag)
  );

  localparam int NV = 15;
  localparam logic [79:0] VEC [NV] = '{
    {2'b00, 6'd0,  1'b0, 35'd13,            1'b0, 35'd5},
    {2'b00, 6'd0,  1'b0, 35'h7_FFFF_FFFF,   1'b1, 35'h7_FFFF_FFFF},
    {2'b00, 6'd0,  1'b1, 35'h0_1234_5678,   1'b1, 35'h5_5555_5555},
    {2'b00, 6'd0,  1'b0, 35'h7_0000_0001,   1'b1, 35'h2_AAAA_AAAA},
    {2'b00, 6'd0,  1'b1, 35'h3_FFFF_0000,   1'b0, 35'h6_DB6D_B6DB},
    {2'b00, 6'd0,  1'b1, 35'd0,             1'b0, 35'h7_FFFF_FFFF},
    {2'b00, 6'd0,  1'b0, 35'h7_FFFF_FFFF,   1'b0, 35'd1},
    {2'b01, 6'd0,  1'b0, 35'h4_0000_0001,   1'b0, 35'd7},
    {2'b01, 6'd0,  1'b1, 35'd5,             1'b0, 35'd3},
    {2'b10, 6'd4,  1'b0, 35'h1_0000_000F,   1'b0, 35'h7_FFFF_FFFB},
    {2'b10, 6'd1,  1'b1, 35'h5_A5A5_A5A5,   1'b0, 35'h3_1234_5677},
    {2'b10, 6'd0,  1'b0, 35'h0_0F0F_0F0F,   1'b1, 35'h2_7654_3210},
    {2'b10, 6'd63, 1'b1, 35'h6_0000_0003,   1'b1, 35'h7_FFFF_FFFF},
    {2'b11, 6'd17, 1'b0, 35'h7_FFFF_FFFF,   1'b0, 35'h1_FFFF_FFFF},
    {2'b10, 6'd34, 1'b0, 35'h2_3456_789A,   1'b1, 35'h7_7777_7777}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic calc(input logic [1:0] md, input logic [5:0] cn,
                      input logic [34:0] mm, input logic [34:0] pm,
                      output logic [34:0] ea, output logic [34:0] eq,
                      output int lat);
    int n;
    logic [34:0] low;
    logic [69:0] prod, comb;
    n = md[1] ? ((cn > 6'd35) ? 35 : int'(cn)) : 35;
    low  = pm & ((35'd1 << n) - 35'd1);
    prod = {35'b0, mm} * {35'b0, low};
    comb = (prod << (35 - n)) | {35'b0, pm >> n};
    ea = comb[69:35];
    eq = comb[34:0];
    if (md[0] && eq[34]) ea = ea + 35'd1;
    lat = (n + 1) / 2 + 3 + int'(md[0]);
  endtask

  task automatic launch(input logic [1:0] md, input logic [5:0] cn,
                        input logic ms, input logic [34:0] mm,
                        input logic ps, input logic [34:0] pm);
    @(negedge clk);
    mode = md; count_in = cn; md_sign = ms; md_mag = mm;
    mr_sign = ps; mr_mag = pm; start = 1'b1;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 200);
  endtask

  task automatic run_vec(input logic [79:0] v, input int idx);
    logic [34:0] ea, eq;
    int lat, cyc;
    logic es;
    calc(v[79:78], v[77:72], v[70:36], v[34:0], ea, eq, lat);
    es = v[71] ^ v[35];
    launch(v[79:78], v[77:72], v[71], v[70:36], v[35], v[34:0]);
    wait_done(cyc);
    // R2 R5 R6 R4: numeric result
    check(acc_mag == ea, "R2/R5/R6", $sformatf("vec%0d acc", idx), acc_mag, ea);
    check(mq_mag == eq, "R4/R5", $sformatf("vec%0d mq", idx), mq_mag, eq);
    check(acc_sign == es && mq_sign == es, "R3", $sformatf("vec%0d sign", idx),
          {acc_sign, mq_sign}, {es, es});
    check(acc_qp == 2'b00, "R7", $sformatf("vec%0d qp", idx), acc_qp, 0);
    check(cyc == lat, "R10", $sformatf("vec%0d latency", idx), cyc, lat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [34:0] ea, eq;
    logic [34:0] ha, hq;
    int lat, cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, done, acc_sign, mq_sign} == 4'b0, "R1", "ctl", {busy, done, acc_sign, mq_sign}, 0);
    check(acc_mag == 0 && mq_mag == 0 && acc_qp == 0, "R1", "data", {acc_qp, acc_mag, mq_mag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R8: pulse, busy drop, hold
    launch(2'b00, 6'd0, 1'b1, 35'h1_2345_6789, 1'b0, 35'h3_0303_0303);
    wait_done(cyc);
    ha = acc_mag; hq = mq_mag;
    @(negedge clk);
    check(!done && !busy, "R8", "done pulse/busy low", {done, busy}, 0);
    repeat (5) @(negedge clk);
    check(acc_mag == ha && mq_mag == hq, "R8", "hold", {acc_mag, mq_mag}, {ha, hq});

    // R9: start while busy ignored
    calc(2'b00, 6'd0, 35'h0_ABCD_EF01, 35'h7_0F0F_0F0F, ea, eq, lat);
    launch(2'b00, 6'd0, 1'b0, 35'h0_ABCD_EF01, 1'b1, 35'h7_0F0F_0F0F);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy, "R9", "busy mid-op", busy, 1);
    mode = 2'b10; count_in = 6'd2; md_sign = 1'b1; md_mag = 35'd3;
    mr_sign = 1'b1; mr_mag = 35'd3; start = 1'b1;
    wait_done(cyc);
    check(acc_mag == ea && mq_mag == eq, "R9", "result unchanged",
          {acc_mag, mq_mag}, {ea, eq});
    check(acc_sign == 1'b1, "R9", "sign unchanged", acc_sign, 1);
    @(negedge clk);
    check(!busy, "R9", "no restart", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule